// File: doc/BRIEF.md
# Prescaled Modulo Interval Timer

This block is a periodic interval timer. A 16-bit counter counts up at a rate taken from the bus clock through a power-of-two prescaler. When the count has reached a programmable limit, the next count returns it to zero. That rollover sets an overflow flag, and the flag can raise an interrupt. The timer sits on an 8-bit register bus. Software reaches one control/status byte, the two bytes of the running count, and the two bytes of the limit.

The timer comes out of reset halted, with the limit at its maximum. Software writes the limit (high byte first) and picks a rate. It then clears the halt bit and takes an interrupt at each rollover. To acknowledge, it reads the control byte and writes a zero into the flag position. A write-only strobe returns the count and the prescaler to zero at any time. An external halt input freezes counting from outside.

Top module: `interval_timer`

## Requirements
- R1: After reset, offset 0 (control) reads 0x20, offsets 1 and 2 (count high, count low) read 0x00, and offsets 3 and 4 (limit high, limit low) read 0xFF. `irq` is 0. Offsets 5 to 7 read 0x00.
- R2: While control bit 5 (halt) is 1 or `halt_in` is 1, the count and the prescaler do not change.
- R3: Control bits 2:0 select the prescale. Values 0 to 6 divide the clock by 1, 2, 4, 8, 16, 32 and 64, and value 7 divides by 64. After a prescaler clear, the count advances on every D-th running cycle.
- R4: When the count equals the limit, the next advance loads 0 instead of count+1. That rollover sets control bit 7 (overflow flag).
- R5: A control write with bit 7 at 0 clears the flag only if a control read has returned the flag as 1 since the last such write. Writing 1 to bit 7 does nothing. A rollover in the same cycle as a clearing write leaves the flag at 1.
- R6: `irq` is a register that follows the AND of the flag and control bit 6 (interrupt enable), one cycle late.
- R7: Writing 1 to control bit 4 clears the count and the prescaler in that cycle. That bit is not stored. Control bits 4 and 3 always read 0.
- R8: Writes to offsets 1 and 2 have no effect on the count.
- R9: Reading offset 1 captures the low count byte. The next read of offset 2 returns the captured byte, and later reads of offset 2 return the live byte.
- R10: A write to offset 3 is held in a buffer and has no effect until offset 4 is written. The limit then becomes {buffer, low byte}.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_in | input | 1 | External halt; freezes counting while 1 |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data byte |
| irq | output | 1 | Registered overflow interrupt request |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never both high in one cycle. They also assume each access is a single-cycle strobe with a stable offset, and that reset is held from time zero until the first access. The stimulus keeps to this: every access is issued by one task that drives one strobe for exactly one cycle, and a cycle with no strobe always follows it. Counting windows open and close with control writes, so the number of running cycles, and from it the expected count and flag, follows from how many idle cycles the bench inserts.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;

  // register offsets
  localparam int A_CTRL   = 0;
  localparam int A_CNT_HI = 1;
  localparam int A_CNT_LO = 2;
  localparam int A_LIM_HI = 3;
  localparam int A_LIM_LO = 4;

  // control byte bit positions
  localparam int B_FLAG  = 7;
  localparam int B_IE    = 6;
  localparam int B_HALT  = 5;
  localparam int B_CLR   = 4;

  localparam logic [BYTE_W-1:0] LIM_BYTE_RST = '1;
endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
  parameter int PRE_W = 6,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] mask;

  // selects >= PRE_W saturate to the widest divider
  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      mask[i] = (i < int'(sel)) ? 1'b1 : 1'b0;
    end
  end

  assign tick = run && !clr && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q <= '0;
    end else if (run) begin
      div_q <= div_q + 1'b1;
    end
  end

  // R3: divide-by-one ticks on every running cycle
  a_r3_div1_every_cycle: assert property (@(posedge clk) disable iff (rst)
    (run && !clr && sel == '0) |-> tick);

  // R2: a halted prescaler keeps its phase
  a_r2_prescaler_frozen: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(div_q));
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic at_limit;

  assign at_limit = (cnt == limit);
  assign wrap     = tick && !clr && at_limit;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= at_limit ? '0 : cnt + 1'b1;
    end
  end

  // R4: a rollover always lands on zero
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));

  // R2: without a tick or a clear the count is frozen
  a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(cnt));

  // R7: the clear strobe empties the count
  a_r7_clear_count: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
endmodule

// File: rtl/itmr_regs.sv
module itmr_regs
  import itmr_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wrap,
  output logic              run,
  output logic              clr,
  output logic [SEL_W-1:0]  sel,
  output logic [CNT_W-1:0]  limit,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq
);
  logic              flag_q, ie_q, halt_q, armed_q;
  logic [SEL_W-1:0]  sel_q;
  logic [BYTE_W-1:0] lim_buf_q, lo_cap_q, rd_mux;
  logic              cap_valid_q;
  logic [CNT_W-1:0]  limit_q;
  logic              wr_ctrl, wr_lim_hi, wr_lim_lo, rd_ctrl, rd_hi, rd_lo;
  logic              clr_attempt;
  logic              unused_wbit3;

  assign wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign wr_lim_hi = bus_wr && (bus_addr == ADDR_W'(A_LIM_HI));
  assign wr_lim_lo = bus_wr && (bus_addr == ADDR_W'(A_LIM_LO));
  assign rd_ctrl   = bus_rd && (bus_addr == ADDR_W'(A_CTRL));
  assign rd_hi     = bus_rd && (bus_addr == ADDR_W'(A_CNT_HI));
  assign rd_lo     = bus_rd && (bus_addr == ADDR_W'(A_CNT_LO));

  assign clr_attempt  = wr_ctrl && !bus_wdata[B_FLAG];
  assign unused_wbit3 = bus_wdata[3];

  assign run   = !halt_q && !halt_in;
  assign clr   = wr_ctrl && bus_wdata[B_CLR];
  assign sel   = sel_q;
  assign limit = limit_q;

  // control fields
  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= 1'b0;
      halt_q <= 1'b1;
      sel_q  <= '0;
    end else if (wr_ctrl) begin
      ie_q   <= bus_wdata[B_IE];
      halt_q <= bus_wdata[B_HALT];
      sel_q  <= bus_wdata[SEL_W-1:0];
    end
  end

  // overflow flag: a rollover wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (wrap) begin
      flag_q <= 1'b1;
    end else if (clr_attempt && armed_q) begin
      flag_q <= 1'b0;
    end
  end

  // the clear is armed by a read that saw the flag set
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
    end else if (clr_attempt) begin
      armed_q <= 1'b0;
    end else if (rd_ctrl && flag_q) begin
      armed_q <= 1'b1;
    end
  end

  // limit: high byte is buffered until the low byte arrives
  always_ff @(posedge clk) begin
    if (rst) begin
      lim_buf_q <= LIM_BYTE_RST;
      limit_q   <= '1;
    end else begin
      if (wr_lim_hi) lim_buf_q <= bus_wdata;
      if (wr_lim_lo) limit_q   <= {lim_buf_q, bus_wdata};
    end
  end

  // count capture for coherent two-byte reads
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cap_q    <= '0;
      cap_valid_q <= 1'b0;
    end else if (rd_hi) begin
      lo_cap_q    <= cnt[BYTE_W-1:0];
      cap_valid_q <= 1'b1;
    end else if (rd_lo) begin
      cap_valid_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (int'(bus_addr))
      A_CTRL:   rd_mux = {flag_q, ie_q, halt_q, 2'b00, sel_q};
      A_CNT_HI: rd_mux = cnt[CNT_W-1:BYTE_W];
      A_CNT_LO: rd_mux = cap_valid_q ? lo_cap_q : cnt[BYTE_W-1:0];
      A_LIM_HI: rd_mux = limit_q[CNT_W-1:BYTE_W];
      A_LIM_LO: rd_mux = limit_q[BYTE_W-1:0];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? rd_mux : '0;
      irq       <= flag_q && ie_q;
    end
  end

  // R4: a rollover always leaves the flag set
  a_r4_flag_on_wrap: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag_q);

  // R5: an unarmed clearing write leaves a set flag alone
  a_r5_clear_needs_read: assert property (@(posedge clk) disable iff (rst)
    (clr_attempt && !armed_q && flag_q) |=> flag_q);

  // R10: a high-byte limit write alone leaves the limit unchanged
  a_r10_limit_buffered: assert property (@(posedge clk) disable iff (rst)
    wr_lim_hi |=> $stable(limit_q));

  // R7: strobe and unused bits never read back as 1
  a_r7_ctrl_reads_zero: assert property (@(posedge clk) disable iff (rst)
    rd_ctrl |=> (bus_rdata[B_CLR] == 1'b0 && bus_rdata[3] == 1'b0));

  // R6: no request while the enable is off
  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    !ie_q |=> !irq);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int PRE_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * BYTE_W;

  logic             run, clr, tick, wrap;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] cnt, limit;

  itmr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .halt_in   (halt_in),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .cnt       (cnt),
    .wrap      (wrap),
    .run       (run),
    .clr       (clr),
    .sel       (sel),
    .limit     (limit),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  itmr_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .clr  (clr),
    .sel  (sel),
    .tick (tick)
  );

  itmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .clr   (clr),
    .limit (limit),
    .cnt   (cnt),
    .wrap  (wrap)
  );

  // R2: no count movement while halted from outside
  a_r2_external_halt: assert property (@(posedge clk) disable iff (rst)
    (halt_in && !clr) |=> $stable(cnt));
endmodule

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       halt_in = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  interval_timer dut (
    .clk(clk), .rst(rst), .halt_in(halt_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: read data is due one cycle after the strobe (R11)
  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    logic [7:0] e;
    string t;
    if (rd_seen) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R11: unexpected read data %h, expected none", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_err++;
          $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = 3'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [7:0] e, input string t);
    @(negedge clk);
    bus_addr = 3'(a); bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_chk++;
    if (irq !== e) begin
      n_err++;
      $display("FAIL %s: irq got %b expected %b", t, irq, e);
    end
  endtask

  function automatic logic [7:0] ctl(input bit ie, input bit hlt, input bit c, input int ps);
    return {1'b0, ie, hlt, c, 1'b0, 3'(ps)};
  endfunction

  // clear, run for m idle cycles between start and halt: (m+2) running cycles
  task automatic run_window(input bit ie, input int ps, input int m);
    wr(0, ctl(ie, 1, 1, ps));
    wr(0, ctl(ie, 0, 0, ps));
    idle(m);
    wr(0, ctl(ie, 1, 0, ps));
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(1);
    // reset state
    chk_irq(1'b0, "R1 reset irq");
    rd(0, 8'h20, "R1 R11 reset control");
    rd(1, 8'h00, "R1 reset count high");
    rd(2, 8'h00, "R1 reset count low");
    rd(3, 8'hFF, "R1 reset limit high");
    rd(4, 8'hFF, "R1 reset limit low");
    rd(6, 8'h00, "R1 unused offset");

    // halted out of reset
    idle(20);
    rd(1, 8'h00, "R2 halted high");
    rd(2, 8'h00, "R2 halted low");

    // buffered limit write
    wr(3, 8'h00);
    rd(3, 8'hFF, "R10 high buffered");
    wr(4, 8'h09);
    rd(3, 8'h00, "R10 limit high committed");
    rd(4, 8'h09, "R10 limit low committed");

    // divide by one, no rollover: 5 ticks
    run_window(0, 0, 3);
    rd(1, 8'h00, "R3 div1 high");
    rd(2, 8'h05, "R3 div1 low");
    rd(0, 8'h20, "R7 control readback");

    // 11 ticks with limit 9: rollover once, count 1
    run_window(0, 0, 9);
    rd(1, 8'h00, "R4 wrap high");
    rd(2, 8'h01, "R4 wrap low");
    rd(0, 8'hA0, "R4 R5 flag kept without prior read");
    wr(0, 8'hA0);
    rd(0, 8'hA0, "R5 writing one has no effect");
    wr(0, 8'h20);
    rd(0, 8'h20, "R5 flag cleared after read");

    // interrupt
    run_window(1, 0, 9);
    idle(2);
    chk_irq(1'b1, "R6 irq with enable");
    wr(0, 8'h20);
    idle(1);
    chk_irq(1'b0, "R6 irq off with enable cleared");
    rd(0, 8'hA0, "R6 flag kept while disabled");
    wr(0, 8'hE0);
    idle(1);
    chk_irq(1'b1, "R6 irq back on");
    wr(0, 8'h60);
    idle(1);
    chk_irq(1'b0, "R6 irq off after flag clear");
    rd(0, 8'h60, "R5 R6 control after clear");
    wr(0, 8'h20);

    // prescaler rates, limit at maximum
    wr(3, 8'hFF);
    wr(4, 8'hFF);
    run_window(0, 2, 18);
    rd(1, 8'h00, "R3 div4 high");
    rd(2, 8'h05, "R3 div4 low");
    run_window(0, 3, 22);
    rd(2, 8'h03, "R3 div8");
    run_window(0, 6, 62);
    rd(2, 8'h01, "R3 div64");
    run_window(0, 7, 126);
    rd(2, 8'h02, "R3 reserved select divides by 64");

    // count is read-only
    wr(1, 8'h55);
    wr(2, 8'hAA);
    rd(1, 8'h00, "R8 count high unchanged");
    rd(2, 8'h02, "R8 count low unchanged");

    // clear strobe
    wr(0, 8'h30);
    rd(0, 8'h20, "R7 strobe not stored, halt kept");
    rd(2, 8'h00, "R7 count cleared");

    // coherent capture: high read at 1 tick, halt at 4 ticks
    wr(0, 8'h30);
    wr(0, 8'h00);
    rd(1, 8'h00, "R9 high read");
    wr(0, 8'h20);
    rd(2, 8'h01, "R9 captured low");
    rd(2, 8'h04, "R9 live low afterwards");

    // external halt
    halt_in = 1'b1;
    wr(0, 8'h30);
    wr(0, 8'h00);
    idle(10);
    wr(0, 8'h20);
    halt_in = 1'b0;
    rd(1, 8'h00, "R2 external halt high");
    rd(2, 8'h00, "R2 external halt low");

    // rollover coinciding with an armed clearing write
    wr(3, 8'h00);
    wr(4, 8'h09);
    wr(0, 8'h30);
    wr(0, 8'h00);
    idle(10);
    rd(0, 8'h80, "R4 flag set while running");
    idle(6);
    wr(0, 8'h00);
    wr(0, 8'h20);
    rd(0, 8'hA0, "R5 rollover beats clear");
    rd(1, 8'h00, "R4 count high after 22 ticks");
    rd(2, 8'h02, "R4 count low after 22 ticks");

    idle(3);
    if (exp_q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL R11: got %0d pending reads expected 0", exp_q.size());
    end
    done = 1'b1;
    report();
  end
endmodule